// File: doc/BRIEF.md
# Channel-Gain Scan Queue Sequencer

This block stores an ordered list of conversion entries for a multiplexed analog front end. Each entry names one of eight input channels and a four-bit range code. While an acquisition runs, every conversion strobe from the pacer takes the entry at the current list position and registers its channel select and range code. It then pulses a start request towards the converter and moves the position forward, wrapping to the first entry after the last one. The registered outputs hold until the converter reports that the conversion has finished.

The host uses a byte-wide write port with four registers. It selects an entry by writing its index to the queue index register and then writes the entry byte to the queue data register. A third register holds the list length minus one. A write of any value to the trigger register starts a single conversion from entry 0 while no acquisition is running. Before an acquisition begins the block checks the list. A list of two or more entries is accepted only when its length is even and every entry's channel parity equals the parity of its position. A rejected start sets a sticky error flag and leaves the sequencer stopped.

Top module: `scan_queue_seq`

## Requirements
- R1: After reset, muxChan, rangeCode, convStart, busy, acqActive and listError are all 0, every entry holds 0 and the list length is 1.
- R2: A write to register 1 sets the entry index. A write to register 2 stores the byte into the entry at that index: channel from bits 2:0, range code from bits 7:4, and bit 3 discarded.
- R3: A write to register 3 sets the list length to the written value plus one (1 to 256). The position wraps to 0 after entry length-1.
- R4: With no acquisition active and busy low, a write of any value to register 0 loads entry 0 onto muxChan and rangeCode. It raises convStart for exactly one cycle, in the cycle after the write, and sets busy.
- R5: While acqActive is set and busy is low, a convStrobe loads the entry at the current position onto the outputs in the following cycle. It pulses convStart and sets busy, and the position then advances by one.
- R6: busy stays set from a conversion start until the cycle after convDone. muxChan and rangeCode do not change while busy is set, and a convStrobe while busy is ignored without advancing the position.
- R7: A list of length 1 is always valid. A longer list is valid only if its length is even and bit 0 of the channel of every entry at index i below the length equals bit 0 of i. Entries at or beyond the length are not checked.
- R8: An acqStart pulse with an invalid list sets listError and leaves acqActive at 0, so later strobes do nothing. listError stays set until an acqStop pulse, which also clears acqActive.
- R9: convStrobe is ignored while no acquisition is active. A write to register 0 is ignored while an acquisition is active.
- R10: An acqStart pulse with a valid list sets acqActive and returns the position to 0, including when it arrives in the middle of a running acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Register select: 0 trigger, 1 index, 2 data, 3 length-1 |
| wrData | input | 8 | Register write data |
| acqStart | input | 1 | Pulse: check the list and start an acquisition |
| acqStop | input | 1 | Pulse: stop the acquisition and clear listError |
| convStrobe | input | 1 | Conversion request from the pacer |
| convDone | input | 1 | Converter reports the conversion has finished |
| muxChan | output | 3 | Registered channel select |
| rangeCode | output | 4 | Registered range/gain code |
| convStart | output | 1 | One-cycle start request to the converter |
| busy | output | 1 | A conversion is pending |
| acqActive | output | 1 | An acquisition is running |
| listError | output | 1 | Sticky flag: a start was rejected |

## Verification
The hardest cases to reach are a strobe that lands while a conversion is still pending, and a parity fault that sits just past the programmed length. The bench holds convDone low across a second strobe and checks that the outputs stay put and that the next accepted strobe takes the following entry, not the one after it. It places a wrong-parity entry at index 3 and first starts with a length of 4, which must be rejected, then rewrites only the length to 2, which must be accepted. Full passes through lists of several lengths, up to all 256 entries, check the wrap point.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  typedef struct packed {
    logic ptrClear;
    logic ptrStep;
    logic capPtr;
    logic capZero;
  } seqStrobes_t;

  localparam logic [1:0] REG_TRIG  = 2'd0;
  localparam logic [1:0] REG_QADDR = 2'd1;
  localparam logic [1:0] REG_QDATA = 2'd2;
  localparam logic [1:0] REG_QLEN  = 2'd3;
endpackage

// File: rtl/scanq_ctrl.sv
module scanq_ctrl
  import scanq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic        acqStart,
  input  logic        acqStop,
  input  logic        convStrobe,
  input  logic        convDone,
  input  logic        listOk,
  output seqStrobes_t strobes,
  output logic        convStart,
  output logic        busy,
  output logic        acqActive,
  output logic        listError
);
  logic startReq, stepNow, swNow;

  always_comb begin
    startReq = acqStart & ~acqStop;
    stepNow  = acqActive & convStrobe & ~busy & ~startReq & ~acqStop;
    swNow    = wrEn & (wrAddr == REG_TRIG) & ~acqActive & ~busy;
    strobes.ptrClear = startReq & listOk;
    strobes.ptrStep  = stepNow;
    strobes.capPtr   = stepNow;
    strobes.capZero  = swNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acqActive <= 1'b0;
      listError <= 1'b0;
      busy      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      if (acqStop)       acqActive <= 1'b0;
      else if (startReq) acqActive <= listOk;

      if (acqStop)                  listError <= 1'b0;
      else if (startReq && !listOk) listError <= 1'b1;

      if (stepNow || swNow) busy <= 1'b1;
      else if (convDone)    busy <= 1'b0;

      convStart <= stepNow | swNow;
    end
  end
endmodule

// File: rtl/scanq_data.sv
module scanq_data
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CHW   = 3,
  parameter int RNGW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [7:0]      wrData,
  input  seqStrobes_t     strobes,
  output logic            listOk,
  output logic [CHW-1:0]  muxChan,
  output logic [RNGW-1:0] rangeCode
);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENTW = CHW + RNGW;
  localparam int RNGLSB = 4;

  logic [ENTW-1:0] qMem [DEPTH];
  logic [IDXW-1:0] qIdx, lenM1, ptr;
  logic            badBelow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) qMem[i] <= '0;
      qIdx  <= '0;
      lenM1 <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_QADDR: qIdx  <= wrData[IDXW-1:0];
        REG_QDATA: qMem[qIdx] <= {wrData[RNGLSB +: RNGW], wrData[CHW-1:0]};
        REG_QLEN:  lenM1 <= wrData[IDXW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    badBelow = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((i <= int'(lenM1)) && (qMem[i][0] != i[0])) badBelow = 1'b1;
    end
    listOk = (lenM1 == '0) || (lenM1[0] && !badBelow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobes.ptrClear) begin
      ptr <= '0;
    end else if (strobes.ptrStep) begin
      ptr <= (ptr == lenM1) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxChan   <= '0;
      rangeCode <= '0;
    end else if (strobes.capPtr) begin
      {rangeCode, muxChan} <= qMem[ptr];
    end else if (strobes.capZero) begin
      {rangeCode, muxChan} <= qMem[0];
    end
  end
endmodule

// File: rtl/scan_queue_seq.sv
module scan_queue_seq
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CHW   = 3,
  parameter int RNGW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [7:0]      wrData,
  input  logic            acqStart,
  input  logic            acqStop,
  input  logic            convStrobe,
  input  logic            convDone,
  output logic [CHW-1:0]  muxChan,
  output logic [RNGW-1:0] rangeCode,
  output logic            convStart,
  output logic            busy,
  output logic            acqActive,
  output logic            listError
);
  seqStrobes_t strobes;
  logic        listOk;

  scanq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .acqStart(acqStart), .acqStop(acqStop), .convStrobe(convStrobe),
    .convDone(convDone), .listOk(listOk), .strobes(strobes),
    .convStart(convStart), .busy(busy), .acqActive(acqActive),
    .listError(listError)
  );

  scanq_data #(.DEPTH(DEPTH), .CHW(CHW), .RNGW(RNGW)) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .listOk(listOk), .muxChan(muxChan),
    .rangeCode(rangeCode)
  );
endmodule

// File: rtl/scan_queue_seq_chk.sv
module scan_queue_seq_chk #(
  parameter int CHW  = 3,
  parameter int RNGW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [1:0]      wrAddr,
  input logic            acqStart,
  input logic            acqStop,
  input logic            convStrobe,
  input logic [CHW-1:0]  muxChan,
  input logic [RNGW-1:0] rangeCode,
  input logic            convStart,
  input logic            busy,
  input logic            acqActive,
  input logic            listError,
  input logic            listOk
);
  assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(muxChan) && $stable(rangeCode)));

  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_error_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(listError) |-> !acqActive);

  assert_start_checks_list_R10: assert property (@(posedge clk) disable iff (!rstN)
    (acqStart && !acqStop) |=> (acqActive == $past(listOk)));

  assert_idle_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!acqActive && convStrobe && !(wrEn && wrAddr == 2'd0)) |=> !convStart);

  assert_strobe_accepted_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acqActive && convStrobe && !busy && !acqStart && !acqStop) |=> (convStart && busy));
endmodule

bind scan_queue_seq scan_queue_seq_chk #(.CHW(CHW), .RNGW(RNGW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .acqStart(acqStart),
  .acqStop(acqStop), .convStrobe(convStrobe), .muxChan(muxChan),
  .rangeCode(rangeCode), .convStart(convStart), .busy(busy),
  .acqActive(acqActive), .listError(listError), .listOk(listOk)
);

// File: tb/scan_queue_seq_test.sv
module scan_queue_seq_test;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0, wrEn = 1'b0, acqStart = 1'b0, acqStop = 1'b0;
  logic       convStrobe = 1'b0, convDone = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] muxChan;
  logic [3:0] rangeCode;
  logic       convStart, busy, acqActive, listError;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [DEPTH];

  scan_queue_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .acqStart(acqStart), .acqStop(acqStop), .convStrobe(convStrobe),
    .convDone(convDone), .muxChan(muxChan), .rangeCode(rangeCode),
    .convStart(convStart), .busy(busy), .acqActive(acqActive),
    .listError(listError)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart();
    acqStart = 1'b1; @(negedge clk); acqStart = 1'b0;
  endtask

  task automatic pulseStop();
    acqStop = 1'b1; @(negedge clk); acqStop = 1'b0;
  endtask

  task automatic loadList(input int len);
    for (int i = 0; i < len; i++) begin
      regWrite(2'd1, 8'(i));
      regWrite(2'd2, img[i]);
    end
    regWrite(2'd3, 8'(len - 1));
  endtask

  task automatic finishConv(input string tag);
    convDone = 1'b1; @(negedge clk); convDone = 1'b0;
    check({tag, " busy clears"}, int'(busy), 0);
  endtask

  task automatic convert(input int idx, input string tag);
    convStrobe = 1'b1; @(negedge clk); convStrobe = 1'b0;
    check({tag, " convStart"}, int'(convStart), 1);
    check({tag, " channel"}, int'(muxChan), int'(img[idx][2:0]));
    check({tag, " range"}, int'(rangeCode), int'(img[idx][7:4]));
    check({tag, " busy"}, int'(busy), 1);
    finishConv(tag);
  endtask

  function automatic logic [7:0] goodEntry(input int i, input int k);
    logic [2:0] ch = 3'((((i * 3 + k) % 4) * 2) + (i % 2));
    logic [3:0] rg = 4'((i + k) % 9);
    return {rg, ((i % 5) == 0) ? 1'b1 : 1'b0, ch};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lens [6] = '{2, 4, 6, 8, 16, 256};
    repeat (3) @(negedge clk);
    check("R1 muxChan", int'(muxChan), 0);
    check("R1 rangeCode", int'(rangeCode), 0);
    check("R1 convStart", int'(convStart), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 acqActive", int'(acqActive), 0);
    check("R1 listError", int'(listError), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R7: sweep of valid lists, run past the wrap point
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < lens[c]; i++) img[i] = goodEntry(i, c);
      loadList(lens[c]);
      pulseStart();
      check("R7 R10 valid list active", int'(acqActive), 1);
      check("R7 no error", int'(listError), 0);
      for (int n = 0; n < lens[c] + 2; n++) convert(n % lens[c], "R2 R3 R5 sweep");
      pulseStop();
      check("R8 stop clears active", int'(acqActive), 0);
    end

    // R7: single entry with odd channel is exempt
    img[0] = {4'd8, 1'b0, 3'd5};
    loadList(1);
    pulseStart();
    check("R7 single entry accepted", int'(acqActive), 1);
    convert(0, "R7 R3 single");
    convert(0, "R7 R3 single wrap");
    pulseStop();

    // R4: software trigger uses entry 0
    img[0] = {4'd3, 1'b0, 3'd6};
    img[1] = {4'd7, 1'b0, 3'd1};
    loadList(2);
    regWrite(2'd0, 8'hA5);
    check("R4 sw convStart", int'(convStart), 1);
    check("R4 sw channel", int'(muxChan), 6);
    check("R4 sw range", int'(rangeCode), 3);
    @(negedge clk);
    check("R4 sw pulse one cycle", int'(convStart), 0);
    finishConv("R4");

    // R8: odd length with good parity rejected
    for (int i = 0; i < 4; i++) img[i] = goodEntry(i, 1);
    loadList(3);
    pulseStart();
    check("R8 odd length error", int'(listError), 1);
    check("R8 odd length inactive", int'(acqActive), 0);
    convStrobe = 1'b1; @(negedge clk); convStrobe = 0;
    check("R8 strobe ignored", int'(convStart), 0);
    check("R8 channel unchanged", int'(muxChan), 6);
    @(negedge clk);
    check("R8 error sticky", int'(listError), 1);
    pulseStop();
    check("R8 stop clears error", int'(listError), 0);

    // R7 R8: parity fault inside the list, then just beyond it
    img[3] = {4'd2, 1'b0, 3'd4};
    loadList(4);
    pulseStart();
    check("R7 parity fault error", int'(listError), 1);
    check("R7 parity fault inactive", int'(acqActive), 0);
    pulseStop();
    regWrite(2'd3, 8'd1);
    pulseStart();
    check("R7 fault beyond length accepted", int'(acqActive), 1);
    check("R7 fault beyond length no error", int'(listError), 0);
    pulseStop();

    // R6: strobe while busy is ignored
    img[3] = goodEntry(3, 1);
    loadList(4);
    pulseStart();
    convStrobe = 1'b1; @(negedge clk); convStrobe = 0;
    check("R6 first convStart", int'(convStart), 1);
    check("R6 first channel", int'(muxChan), int'(img[0][2:0]));
    convStrobe = 1'b1; @(negedge clk); convStrobe = 0;
    check("R6 busy strobe no start", int'(convStart), 0);
    check("R6 busy channel held", int'(muxChan), int'(img[0][2:0]));
    check("R6 busy range held", int'(rangeCode), int'(img[0][7:4]));
    check("R6 still busy", int'(busy), 1);
    finishConv("R6");
    convert(1, "R6 no skipped entry");

    // R9: sw trigger ignored while active
    regWrite(2'd0, 8'h00);
    check("R9 sw ignored active", int'(convStart), 0);
    check("R9 sw no busy", int'(busy), 0);

    // R10: restart mid-list returns to entry 0
    pulseStart();
    convert(0, "R10 restart");
    convert(1, "R10 continue");
    pulseStop();

    // R9: strobe ignored while inactive
    convStrobe = 1'b1; @(negedge clk); convStrobe = 0;
    check("R9 idle strobe ignored", int'(convStart), 0);
    check("R9 idle no busy", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule